// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Unit

This block sits beside a real-time clock's timekeeper. It holds a programmed alarm moment, split into a time word and a calendar word, and compares it on every timekeeper tick against the running BCD time and date. Six per-field match enables choose which fields take part in the comparison. When every enabled field agrees, the block raises an alarm event. The event is latched into a flag that clears when it is read, and the flag drives a single active-high level interrupt through a mask bit.

Software sets the mask bit by writing 1 to one register and clears it by writing 1 to another. The current mask value can be read from a third register. A status register tells software whether the last values written into the two alarm registers were legal BCD values.

Top module: `rtc_alarm_unit`

## Requirements
- R1: Word address 0 is the alarm time register and word address 1 is the alarm calendar register. The alarm time fields are hundredths[7:0], seconds[14:8], minutes[22:16] and hours[29:24]. The alarm calendar fields are month[7:3] and date[13:8]. Bits outside these fields are dropped on write and read as 0, so writing all ones reads back as 0x3F7F7FFF for the time register and 0x00003FF8 for the calendar register.
- R2: Word address 2 holds the match enables: bit 0 hundredths, bit 1 seconds, bit 2 minutes, bit 3 hours, bit 4 date, bit 5 month. On a cycle where `tick` is high, an alarm event occurs when every enabled field of `curTime`/`curCal` (at the R1 positions) equals the alarm field. Fields that are not enabled, and all other bits, are ignored.
- R3: An event occurs only on the first tick of a run of matching ticks. Further events need a tick that does not match, followed by a tick that matches again.
- R4: When all six match enables are 0, no alarm event is ever generated.
- R5: Word address 3 is the event register, with the alarm flag at bit 6. A read of this register returns the pending flag, and the flag clears at the clock edge of that read.
- R6: If an alarm event and a read of the event register fall in the same cycle, the read returns the old flag value and the flag stays set afterwards.
- R7: Writing a 1 to bit 6 of address 4 sets the interrupt mask bit. Writing a 1 to bit 6 of address 5 clears it. Writing 0 to bit 6 of either address has no effect. Address 6 returns the mask at bit 6.
- R8: `irq` is high exactly while the alarm flag is set and the mask bit is set. It stays high over idle cycles and falls after the event register is read.
- R9: Address 7 is the status register. Bit 2 shows that the last alarm time written had hundredths 00-99, seconds 00-59, minutes 00-59 and hours 00-23, all in valid BCD. Bit 3 shows that the last alarm calendar written had date 01-31 and month 01-12, both in valid BCD.
- R10: After reset, every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and compare clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe marking a new timekeeper value |
| curTime | input | 32 | Running BCD time word |
| curCal | input | 32 | Running BCD calendar word |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears the event flag at address 3) |
| regAddr | input | 4 | Word address of the register access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| irq | output | 1 | Active-high level interrupt |

## Verification
Two functions can fall in the same cycle: a matching tick that sets the alarm flag, and a software read that clears it. The bench provokes this by raising an event first, letting a non-matching tick pass, and then driving a matching tick together with a read of the event register in one cycle. It judges the result by three observations: the read must return the old flag, and both a later read and `irq` must show the flag still pending. Mask set/clear writes landing while a flag is pending are also checked at `irq`.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int NUM_FIELDS = 6;
  localparam int EVT_BIT    = 6;
  localparam int STS_TIME   = 2;
  localparam int STS_CAL    = 3;

  localparam int ADR_ALM_TIME = 0;
  localparam int ADR_ALM_CAL  = 1;
  localparam int ADR_ALM_EN   = 2;
  localparam int ADR_EVENTS   = 3;
  localparam int ADR_INT_SET  = 4;
  localparam int ADR_INT_CLR  = 5;
  localparam int ADR_INT_MASK = 6;
  localparam int ADR_STATUS   = 7;

  typedef struct packed {
    logic wrTime;
    logic wrCal;
    logic wrEn;
    logic rdEvents;
    logic intSet;
    logic intClr;
  } regStrobeT;

  // field order matches the enable-bit order: hund, sec, min, hour, date, month
  function automatic int fieldLsb(input int idx);
    case (idx)
      0: return 0;
      1: return 8;
      2: return 16;
      3: return 24;
      4: return 8;
      default: return 3;
    endcase
  endfunction

  function automatic int fieldWidth(input int idx);
    case (idx)
      0: return 8;
      1: return 7;
      2: return 7;
      3: return 6;
      4: return 6;
      default: return 5;
    endcase
  endfunction

  function automatic logic [31:0] fieldMask(input bit calWord);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if ((i >= 4) == calWord) begin
        for (int b = 0; b < fieldWidth(i); b++) m[fieldLsb(i) + b] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic bcdInRange(input logic [7:0] v, input int lo, input int hi);
    int value;
    value = int'(v[7:4]) * 10 + int'(v[3:0]);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9) && (value >= lo) && (value <= hi);
  endfunction

endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobeT         strb
);

  always_comb begin
    strb          = '0;
    strb.wrTime   = regWrEn && (regAddr == ADDR_W'(ADR_ALM_TIME));
    strb.wrCal    = regWrEn && (regAddr == ADDR_W'(ADR_ALM_CAL));
    strb.wrEn     = regWrEn && (regAddr == ADDR_W'(ADR_ALM_EN));
    strb.intSet   = regWrEn && (regAddr == ADDR_W'(ADR_INT_SET));
    strb.intClr   = regWrEn && (regAddr == ADDR_W'(ADR_INT_CLR));
    strb.rdEvents = regRdEn && (regAddr == ADDR_W'(ADR_EVENTS));
  end

endmodule

// File: rtl/rtc_alarm_datapath.sv
module rtc_alarm_datapath
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [DATA_W-1:0] curTime,
  input  logic [DATA_W-1:0] curCal,
  input  regStrobeT         strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);

  localparam logic [DATA_W-1:0] TIME_MASK = DATA_W'(fieldMask(1'b0));
  localparam logic [DATA_W-1:0] CAL_MASK  = DATA_W'(fieldMask(1'b1));

  logic [DATA_W-1:0]     almTime, almCal;
  logic [NUM_FIELDS-1:0] almEn, fieldHit;
  logic evtFlag, intMask, timeOk, calOk, matchPrev;
  logic matchNow, alarmEvent, wrTimeOk, wrCalOk;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    localparam int LSB = fieldLsb(gi);
    localparam int W   = fieldWidth(gi);
    logic [W-1:0] curV, almV;
    if (gi < 4) begin : g_time
      assign curV = curTime[LSB +: W];
      assign almV = almTime[LSB +: W];
    end else begin : g_cal
      assign curV = curCal[LSB +: W];
      assign almV = almCal[LSB +: W];
    end
    assign fieldHit[gi] = ~almEn[gi] | (curV == almV);
  end

  assign matchNow   = (|almEn) & (&fieldHit);
  assign alarmEvent = tick & matchNow & ~matchPrev;

  assign wrTimeOk = bcdInRange(regWrData[7:0], 0, 99)
                  & bcdInRange({1'b0, regWrData[14:8]}, 0, 59)
                  & bcdInRange({1'b0, regWrData[22:16]}, 0, 59)
                  & bcdInRange({2'b0, regWrData[29:24]}, 0, 23);
  assign wrCalOk  = bcdInRange({2'b0, regWrData[13:8]}, 1, 31)
                  & bcdInRange({3'b0, regWrData[7:3]}, 1, 12);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almTime   <= '0;
      almCal    <= '0;
      almEn     <= '0;
      evtFlag   <= 1'b0;
      intMask   <= 1'b0;
      timeOk    <= 1'b0;
      calOk     <= 1'b0;
      matchPrev <= 1'b0;
    end else begin
      if (strb.wrTime) begin
        almTime <= regWrData & TIME_MASK;
        timeOk  <= wrTimeOk;
      end
      if (strb.wrCal) begin
        almCal <= regWrData & CAL_MASK;
        calOk  <= wrCalOk;
      end
      if (strb.wrEn) almEn <= regWrData[NUM_FIELDS-1:0];
      if (strb.intSet && regWrData[EVT_BIT]) intMask <= 1'b1;
      else if (strb.intClr && regWrData[EVT_BIT]) intMask <= 1'b0;
      // a fresh event outranks the read-clear so it is never lost
      if (alarmEvent) evtFlag <= 1'b1;
      else if (strb.rdEvents) evtFlag <= 1'b0;
      if (tick) matchPrev <= matchNow;
    end
  end

  assign irq = evtFlag & intMask;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADR_ALM_TIME): regRdData = almTime;
      ADDR_W'(ADR_ALM_CAL):  regRdData = almCal;
      ADDR_W'(ADR_ALM_EN):   regRdData[NUM_FIELDS-1:0] = almEn;
      ADDR_W'(ADR_EVENTS):   regRdData[EVT_BIT] = evtFlag;
      ADDR_W'(ADR_INT_MASK): regRdData[EVT_BIT] = intMask;
      ADDR_W'(ADR_STATUS): begin
        regRdData[STS_TIME] = timeOk;
        regRdData[STS_CAL]  = calOk;
      end
      default: regRdData = '0;
    endcase
  end

  assert_event_sets_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvent |=> evtFlag);
  assert_read_clears_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEvents && !alarmEvent) |=> !evtFlag);
  assert_event_survives_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEvents && alarmEvent) |=> evtFlag);
  assert_single_fire_R3: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvent |=> !alarmEvent);
  assert_no_enable_no_event_R4: assert property (@(posedge clk) disable iff (!rstN)
    (almEn == '0) |-> !alarmEvent);
  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.intSet && regWrData[EVT_BIT]) |=> intMask);
  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.intClr && regWrData[EVT_BIT]) |=> !intMask);
  assert_irq_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !strb.rdEvents && !strb.intClr) |=> irq);

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [DATA_W-1:0] curTime,
  input  logic [DATA_W-1:0] curCal,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);

  regStrobeT strb;

  rtc_alarm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  rtc_alarm_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .curTime   (curTime),
    .curCal    (curCal),
    .strb      (strb),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irq       (irq)
  );

endmodule

// File: tb/rtc_alarm_unit_tb.sv
`timescale 1ns/1ps
module rtc_alarm_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] curTime = '0, curCal = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_unit u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .curTime(curTime), .curCal(curCal),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  localparam logic [31:0] ALM_T   = 32'h10203000;
  localparam logic [31:0] ALM_C   = 32'h00000518;
  localparam logic [31:0] HIT_T   = 32'h10203045;
  localparam logic [31:0] HIT_C   = 32'h1920051B;
  localparam logic [31:0] MISS_T  = 32'h10203100;
  localparam logic [31:0] EVT     = 32'h00000040;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic doTick(input logic [31:0] t, input logic [31:0] c);
    @(negedge clk);
    tick = 1'b1; curTime = t; curCal = c;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      regRead(4'(a), d);
      chk("R10 reset register", d, 32'h0);
    end
    chk("R10 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic testRegisters();
    logic [31:0] d;
    regWrite(4'd0, 32'hFFFFFFFF);
    regRead(4'd0, d);  chk("R1 time field mask", d, 32'h3F7F7FFF);
    regWrite(4'd1, 32'hFFFFFFFF);
    regRead(4'd1, d);  chk("R1 calendar field mask", d, 32'h00003FF8);
    regRead(4'd7, d);  chk("R9 illegal both", d, 32'h0);
    regWrite(4'd0, 32'h12345678);
    regWrite(4'd1, 32'h00001530);
    regRead(4'd0, d);  chk("R1 time readback", d, 32'h12345678);
    regRead(4'd7, d);  chk("R9 both valid", d, 32'h0000000C);
    regWrite(4'd0, 32'h00006000);
    regRead(4'd7, d);  chk("R9 seconds 60 invalid", d, 32'h00000008);
    regWrite(4'd0, 32'h0000000A);
    regRead(4'd7, d);  chk("R9 bad BCD digit", d, 32'h00000008);
    regWrite(4'd1, 32'h00000198);
    regRead(4'd7, d);  chk("R9 month 13 invalid", d, 32'h0);
  endtask

  task automatic testMatch();
    logic [31:0] d;
    regWrite(4'd0, ALM_T);
    regWrite(4'd1, ALM_C);
    regWrite(4'd2, 32'h0000003E);
    regWrite(4'd4, EVT);
    regRead(4'd6, d);  chk("R7 mask set", d, EVT);
    doTick(MISS_T, HIT_C);
    chk("R2 no event on mismatch", {31'b0, irq}, 32'h0);
    doTick(HIT_T, HIT_C);
    chk("R8 irq on match", {31'b0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R8 irq level holds", {31'b0, irq}, 32'h1);
    regRead(4'd3, d);  chk("R5 flag read", d, EVT);
    chk("R8 irq drops after read", {31'b0, irq}, 32'h0);
    regRead(4'd3, d);  chk("R5 flag cleared", d, 32'h0);
  endtask

  task automatic testRefire();
    logic [31:0] d;
    doTick(HIT_T, HIT_C);
    regRead(4'd3, d);  chk("R3 no refire on held match", d, 32'h0);
    doTick(MISS_T, HIT_C);
    doTick(32'h10203099, HIT_C);
    regRead(4'd3, d);  chk("R3 refire after change", d, EVT);
  endtask

  task automatic testSingleField();
    logic [31:0] d;
    regWrite(4'd2, 32'h00000020);
    doTick(32'h00000000, 32'h00000520);
    regRead(4'd3, d);  chk("R2 month mismatch", d, 32'h0);
    doTick(32'h23595999, 32'h00003F18);
    regRead(4'd3, d);  chk("R2 month only match", d, EVT);
  endtask

  task automatic testNoEnable();
    logic [31:0] d;
    regWrite(4'd2, 32'h0);
    doTick(MISS_T, 32'h0);
    doTick(HIT_T, HIT_C);
    doTick(ALM_T, ALM_C);
    regRead(4'd3, d);  chk("R4 no event with zero enables", d, 32'h0);
    chk("R4 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic testMask();
    logic [31:0] d;
    regWrite(4'd2, 32'h0000003E);
    regWrite(4'd5, 32'h0);
    regRead(4'd6, d);  chk("R7 zero write to disable ignored", d, EVT);
    regWrite(4'd5, EVT);
    regRead(4'd6, d);  chk("R7 mask cleared", d, 32'h0);
    doTick(MISS_T, HIT_C);
    doTick(HIT_T, HIT_C);
    chk("R8 masked irq low", {31'b0, irq}, 32'h0);
    regWrite(4'd4, 32'h0);
    chk("R7 zero write to enable ignored", {31'b0, irq}, 32'h0);
    regWrite(4'd4, EVT);
    chk("R8 irq rises on unmask", {31'b0, irq}, 32'h1);
    regRead(4'd3, d);  chk("R5 masked flag pending", d, EVT);
  endtask

  task automatic testCollision();
    logic [31:0] d;
    doTick(MISS_T, HIT_C);
    doTick(HIT_T, HIT_C);
    doTick(MISS_T, HIT_C);
    chk("R6 flag pending before collision", {31'b0, irq}, 32'h1);
    @(negedge clk);
    tick = 1'b1; curTime = HIT_T; curCal = HIT_C;
    regRdEn = 1'b1; regAddr = 4'd3;
    #1 d = regRdData;
    @(negedge clk);
    tick = 1'b0; regRdEn = 1'b0;
    chk("R6 collision read returns old flag", d, EVT);
    chk("R6 irq stays high", {31'b0, irq}, 32'h1);
    regRead(4'd3, d);  chk("R6 flag kept", d, EVT);
    regRead(4'd3, d);  chk("R5 clear after collision", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegisters();
    testMatch();
    testRefire();
    testSingleField();
    testNoEnable();
    testMask();
    testCollision();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule